// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts

This block is a 64-deep byte queue placed between a host data port and an internal data path. Either side may push a byte, and one consumer pops bytes in arrival order. The block reports how many bytes it holds as a count from 0 to 64. Two alert flags are derived from a single programmable water level. The high alert marks a queue that is close to full, and the low alert marks a queue that is close to empty.

A push into a full queue is dropped and latches an overflow flag. That flag stays set until a flush. A flush empties the queue in one clock cycle. When both producers push in the same cycle, the host wins. A popped byte appears on a registered output port.

Top module: `fifo_wm`

## Requirements
- R1: After reset, `fill_len` is 0, `lo_alert` is 1, `hi_alert` is 0, `ovf_flag` is 0 and `rd_byte` is 0.
- R2: Bytes leave in the order they were accepted. A pop on a non-empty queue places the oldest byte on `rd_byte` at the clock edge that samples `rd_en`. `fill_len` counts the stored bytes, from 0 up to 64.
- R3: `hi_alert` is 1 exactly when `fill_len` >= 64 - `water_lvl`. With `water_lvl` = 0, it is 1 only when the queue is full.
- R4: `lo_alert` is 1 exactly when `fill_len` <= `water_lvl`.
- R5: A push while `fill_len` is 64 stores nothing and sets `ovf_flag`. This holds even when a pop happens in the same cycle. The pop still proceeds, so `fill_len` becomes 63. Only a flush clears `ovf_flag`.
- R6: A flush empties the queue and clears `ovf_flag` at the next edge. Any push or pop in the same cycle is ignored, and `rd_byte` keeps its value.
- R7: A pop on an empty queue leaves `rd_byte` and `fill_len` unchanged, and it does not move any pointer.
- R8: A push and a pop in the same cycle, with 0 < `fill_len` < 64, leave `fill_len` unchanged.
- R9: When `host_wr_en` and `core_wr_en` are both 1, only `host_wr_byte` is stored, and the internal byte is dropped without setting `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host push strobe |
| host_wr_byte | input | 8 | Host push data |
| core_wr_en | input | 1 | Internal-path push strobe |
| core_wr_byte | input | 8 | Internal-path push data |
| rd_en | input | 1 | Pop strobe |
| rd_byte | output | 8 | Last popped byte (registered) |
| water_lvl | input | 6 | Water level for both alerts |
| flush | input | 1 | Empty the queue and clear overflow |
| fill_len | output | 7 | Number of stored bytes |
| hi_alert | output | 1 | Near-full alert |
| lo_alert | output | 1 | Near-empty alert |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is a completely full queue that receives a push together with a pop. Right behind it are the exact alert boundaries at the top of the range.

The directed sequence fills all 64 entries and then pushes into the full queue, both with and without a concurrent pop. Random stimulus then alternates between push-heavy and pop-heavy phases of 200 cycles. This drives the count repeatedly to both ends, while the water level and occasional flushes are varied.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        logic wr_fire;
        logic rd_fire;
    } ptr_op_t;

    function automatic int unsigned hi_threshold(int unsigned depth, int unsigned lvl);
        return depth - lvl;
    endfunction
endpackage

// File: rtl/fifo_wm_arb.sv
module fifo_wm_arb
    import fifo_wm_pkg::*;
(
    input  wr_req_t host_req,
    input  wr_req_t core_req,
    output wr_req_t win_req
);
    always_comb begin
        if (host_req.vld) begin
            win_req = host_req;
        end else begin
            win_req = core_req;
        end
    end
endmodule

// File: rtl/fifo_wm_ctrl.sv
module fifo_wm_ctrl
    import fifo_wm_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_vld,
    input  logic          rd_en,
    output ptr_op_t       op,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [LW-1:0] count,
    output logic          ovf
);
    localparam logic [LW-1:0] FULL_C = LW'(DEPTH);

    logic is_full;
    logic is_empty;

    assign is_full    = (count == FULL_C);
    assign is_empty   = (count == '0);
    assign op.wr_fire = wr_vld && !flush && !is_full;
    assign op.rd_fire = rd_en && !flush && !is_empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (op.wr_fire) wptr <= wptr + AW'(1);
            if (op.rd_fire) rptr <= rptr + AW'(1);
            unique case ({op.wr_fire, op.rd_fire})
                2'b10:   count <= count + LW'(1);
                2'b01:   count <= count - LW'(1);
                default: count <= count;
            endcase
            if (wr_vld && is_full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/fifo_wm_store.sv
module fifo_wm_store
    import fifo_wm_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  ptr_op_t       op,
    input  logic [AW-1:0] wptr,
    input  logic [AW-1:0] rptr,
    input  byte_t         wdata,
    output byte_t         rd_byte
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op.wr_fire) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_byte <= '0;
        end else if (op.rd_fire) begin
            rd_byte <= mem[rptr];
        end
    end
endmodule

// File: rtl/fifo_wm_alert.sv
module fifo_wm_alert
    import fifo_wm_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned LW    = AW + 1
) (
    input  logic [LW-1:0] count,
    input  logic [AW-1:0] water,
    output logic          hi,
    output logic          lo
);
    localparam int unsigned CW = LW + 1;

    logic [CW-1:0] cnt_w;
    logic [CW-1:0] lvl_w;
    logic [CW-1:0] hi_thr;

    assign cnt_w  = CW'(count);
    assign lvl_w  = CW'(water);
    assign hi_thr = CW'(hi_threshold(DEPTH, 0)) - lvl_w;
    assign hi     = (cnt_w >= hi_thr);
    assign lo     = (cnt_w <= lvl_w);
endmodule

// File: rtl/fifo_wm.sv
module fifo_wm
    import fifo_wm_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [BYTE_W-1:0] host_wr_byte,
    input  logic              core_wr_en,
    input  logic [BYTE_W-1:0] core_wr_byte,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic [AW-1:0]     water_lvl,
    input  logic              flush,
    output logic [LW-1:0]     fill_len,
    output logic              hi_alert,
    output logic              lo_alert,
    output logic              ovf_flag
);
    wr_req_t       host_req, core_req, win_req;
    ptr_op_t       op;
    logic [AW-1:0] wptr, rptr;

    assign host_req = '{vld: host_wr_en, data: host_wr_byte};
    assign core_req = '{vld: core_wr_en, data: core_wr_byte};

    fifo_wm_arb u_arb (
        .host_req (host_req),
        .core_req (core_req),
        .win_req  (win_req)
    );

    fifo_wm_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_vld (win_req.vld),
        .rd_en  (rd_en),
        .op     (op),
        .wptr   (wptr),
        .rptr   (rptr),
        .count  (fill_len),
        .ovf    (ovf_flag)
    );

    fifo_wm_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wptr    (wptr),
        .rptr    (rptr),
        .wdata   (win_req.data),
        .rd_byte (rd_byte)
    );

    fifo_wm_alert #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_alert (
        .count (fill_len),
        .water (water_lvl),
        .hi    (hi_alert),
        .lo    (lo_alert)
    );
endmodule

// File: rtl/fifo_wm_chk.sv
module fifo_wm_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned LW    = AW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr_en,
    input logic          core_wr_en,
    input logic          rd_en,
    input logic [7:0]    rd_byte,
    input logic          flush,
    input logic [LW-1:0] fill_len,
    input logic          ovf_flag
);
    logic push_any;
    assign push_any = host_wr_en || core_wr_en;

    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        fill_len <= LW'(DEPTH));

    a_r5_full_push_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (fill_len == LW'(DEPTH) && push_any && !flush) |=> ovf_flag);

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flush) |=> ovf_flag);

    a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill_len == '0 && !ovf_flag));

    a_r6_flush_keeps_out: assert property (@(posedge clk) disable iff (rst)
        flush |=> $stable(rd_byte));

    a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (fill_len == '0 && rd_en && !push_any && !flush) |=> ($stable(rd_byte) && fill_len == '0));

    a_r8_push_pop_len: assert property (@(posedge clk) disable iff (rst)
        (fill_len != '0 && fill_len != LW'(DEPTH) && push_any && rd_en && !flush) |=> $stable(fill_len));
endmodule

bind fifo_wm fifo_wm_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr_en (host_wr_en),
    .core_wr_en (core_wr_en),
    .rd_en      (rd_en),
    .rd_byte    (rd_byte),
    .flush      (flush),
    .fill_len   (fill_len),
    .ovf_flag   (ovf_flag)
);

// File: tb/fifo_wm_tb.sv
`timescale 1ns/1ps
module fifo_wm_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr_en = 1'b0, core_wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0;
    logic [7:0] host_wr_byte = '0, core_wr_byte = '0;
    logic [5:0] water_lvl = '0;
    logic [7:0] rd_byte;
    logic [6:0] fill_len;
    logic       hi_alert, lo_alert, ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] q[$];
    logic [7:0] exp_rd = '0;
    bit         exp_ovf = 1'b0;

    always #5 clk = ~clk;

    fifo_wm u_dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_byte(host_wr_byte),
        .core_wr_en(core_wr_en), .core_wr_byte(core_wr_byte),
        .rd_en(rd_en), .rd_byte(rd_byte), .water_lvl(water_lvl),
        .flush(flush), .fill_len(fill_len), .hi_alert(hi_alert),
        .lo_alert(lo_alert), .ovf_flag(ovf_flag)
    );

    function automatic bit f_hi(int len, int wl);
        return len >= (64 - wl);
    endfunction

    function automatic bit f_lo(int len, int wl);
        return len <= wl;
    endfunction

    task automatic chk(string tg, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
        end
    endtask

    task automatic check_all(string tg);
        chk({tg, "/R2"}, "fill_len", int'(fill_len), q.size());
        chk({tg, "/R2"}, "rd_byte", int'(rd_byte), int'(exp_rd));
        chk({tg, "/R3"}, "hi_alert", int'(hi_alert), int'(f_hi(q.size(), int'(water_lvl))));
        chk({tg, "/R4"}, "lo_alert", int'(lo_alert), int'(f_lo(q.size(), int'(water_lvl))));
        chk({tg, "/R5"}, "ovf_flag", int'(ovf_flag), int'(exp_ovf));
    endtask

    task automatic step(bit hp, logic [7:0] hd, bit cp, logic [7:0] cd,
                        bit pp, bit fl, logic [5:0] wl, string tg);
        @(negedge clk);
        host_wr_en = hp; host_wr_byte = hd;
        core_wr_en = cp; core_wr_byte = cd;
        rd_en = pp; flush = fl; water_lvl = wl;
        if (fl) begin
            q.delete();
            exp_ovf = 1'b0;
        end else begin
            bit full_before;
            full_before = (q.size() == 64);
            if (pp && q.size() != 0) exp_rd = q.pop_front();
            if (hp || cp) begin
                if (full_before) exp_ovf = 1'b1;
                else q.push_back(hp ? hd : cd);
            end
        end
        @(posedge clk);
        #1;
        check_all(tg);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "fill_len", int'(fill_len), 0);
        chk("R1", "lo_alert", int'(lo_alert), 1);
        chk("R1", "hi_alert", int'(hi_alert), 0);
        chk("R1", "ovf_flag", int'(ovf_flag), 0);
        chk("R1", "rd_byte", int'(rd_byte), 0);

        // R7: pop on empty
        step(0, 8'h00, 0, 8'h00, 1, 0, 6'd4, "R7");
        // R9: both sources push, host wins
        step(1, 8'hA5, 1, 8'h3C, 0, 0, 6'd4, "R9");
        chk("R9", "fill_len", int'(fill_len), 1);
        step(0, 8'h00, 0, 8'h00, 1, 0, 6'd4, "R9");
        chk("R9", "rd_byte", int'(rd_byte), 8'hA5);
        // R7: empty again, popped byte held
        step(0, 8'h00, 0, 8'h00, 1, 0, 6'd4, "R7");
        chk("R7", "rd_byte", int'(rd_byte), 8'hA5);

        // Fill to 64 with a water level of 5 (R3 boundaries at 59)
        for (int i = 0; i < 64; i++) begin
            step(i[0], 8'(i), !i[0], 8'(i + 100), 0, 0, 6'd5, "R3");
        end
        chk("R3", "hi_alert", int'(hi_alert), 1);
        // R5: push into full queue
        step(1, 8'hEE, 0, 8'h00, 0, 0, 6'd5, "R5");
        chk("R5", "ovf_flag", int'(ovf_flag), 1);
        // R5: push plus pop at full, push dropped
        step(1, 8'hDD, 0, 8'h00, 1, 0, 6'd0, "R5");
        chk("R5", "fill_len", int'(fill_len), 63);
        // R8: push plus pop at 63
        step(0, 8'h00, 1, 8'h77, 1, 0, 6'd0, "R8");
        chk("R8", "fill_len", int'(fill_len), 63);
        // R2: drain a few bytes in order
        for (int i = 0; i < 8; i++) step(0, 8'h00, 0, 8'h00, 1, 0, 6'd32, "R2");
        // R6: flush with simultaneous push and pop
        step(1, 8'h11, 1, 8'h22, 1, 1, 6'd32, "R6");
        chk("R6", "fill_len", int'(fill_len), 0);
        chk("R6", "ovf_flag", int'(ovf_flag), 0);

        // Random phases
        for (int i = 0; i < 4000; i++) begin
            bit heavy_push;
            int pw, pr;
            heavy_push = ((i / 200) % 2) == 0;
            pw = heavy_push ? 80 : 25;
            pr = heavy_push ? 25 : 80;
            step(($urandom % 100) < pw / 2, 8'($urandom),
                 ($urandom % 100) < pw / 2, 8'($urandom),
                 ($urandom % 100) < pr, ($urandom % 100) == 0,
                 6'($urandom), "RND");
        end

        @(negedge clk);
        host_wr_en = 0; core_wr_en = 0; rd_en = 0; flush = 0;
        summary();
    end
endmodule